// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns characters into a framed asynchronous serial bit stream. Software or a neighbouring controller writes one character at a time into a single-entry holding buffer with a one-cycle write strobe. When the shifter is idle, the character moves into the shift register and the buffer frees up for the next write. A six-bit line-control input selects the word length (5 to 8 bits), the number of stop bits (one or two) and the parity mode. The parity modes are none, odd, even, a parity bit that is always 1 and a parity bit that is always 0.

Bit timing comes from a one-cycle pulse at sixteen times the bit rate. A separate baud generator supplies this pulse. Each bit on the line lasts sixteen of these pulses. A send-break input pulls the line low for as long as it is held. After it is released, the line goes back to mark for one full bit time before any further character starts.

Two status outputs are provided. One says the holding buffer can take a character. The other says the whole transmitter has gone quiet. The serial output is a plain port, so it can be wired back into a receiver for loop-back use.

Top module: `uart_tx`

## Requirements
- R1: Word length follows `lineCtrl[1:0]`: code 0 sends 5 data bits, 1 sends 6, 2 sends 7 and 3 sends 8.
- R2: `lineCtrl[2]` = 0 ends each frame with one high stop bit; `lineCtrl[2]` = 1 ends it with two high stop bits.
- R3: `lineCtrl[5]` = 0 sends no parity bit. When `lineCtrl[5]` = 1, one parity bit follows the data bits, chosen by `lineCtrl[4:3]`: 00 makes the count of ones over data plus parity odd, 01 makes it even, 10 sends a constant 1 and 11 sends a constant 0.
- R4: Every frame begins with one low start bit, followed by the data bits least significant first. Each bit lasts 16 baud ticks.
- R5: The line idles high. Whenever `txDone` is high, `txOut` is high.
- R6: `bufEmpty` is 1 after reset. A write strobe while `bufEmpty` is 1 makes it 0 on the next cycle. With no write it stays 1. It returns to 1 when the character moves into the shifter.
- R7: A write strobe while `bufEmpty` is 0 is ignored: no character is lost, replaced or added.
- R8: `txDone` is 1 only when the holding buffer is empty and no frame is being shifted out. It is 0 from the cycle after an accepted write until the last stop bit has ended.
- R9: From the cycle after `sendBreak` is seen high, `txOut` is low for as long as `sendBreak` stays high. This abandons any frame in progress. A character in the holding buffer is kept and is not sent during the break.
- R10: After `sendBreak` falls, `txOut` is high from the next cycle and stays high for at least 16 baud ticks before the next start bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baudTick | input | 1 | One-cycle pulse at 16 times the bit rate |
| lineCtrl | input | 6 | Frame settings: [1:0] word length, [2] stop bits, [5:3] parity mode |
| sendBreak | input | 1 | Hold the line low while high |
| wrStrobe | input | 1 | Write strobe for the holding buffer |
| wrData | input | 8 | Character to write; unused upper bits are ignored for shorter words |
| txOut | output | 1 | Serial line output |
| bufEmpty | output | 1 | Holding buffer can take a character |
| txDone | output | 1 | Buffer and shift register both empty |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a write strobe and the hand-off of the buffered character into the shifter. The bench provokes this by strobing again in the very cycle after an accepted write, and again while a second character is waiting. It judges the result by the exact sequence of frames that a model receiver decodes on the line. The second pair is a break arriving in the middle of a frame while a fresh character is written into the buffer. This is judged by a line held low throughout the break, a buffer that stays full, a recovery gap of at least sixteen ticks, and then correct delivery of the held character.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int WORD_MAX = 8;
  localparam int WORD_MIN = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2,
    ST_BRK,
    ST_BRKREC
  } txState_t;

  typedef enum logic [1:0] {
    LN_MARK,
    LN_SPACE,
    LN_DATA,
    LN_PAR
  } lineSel_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic     load;
    logic     shift;
    logic     clrTick;
    lineSel_t lineSel;
  } txStrobe_t;

endpackage

// File: rtl/uart_tx_dp.sv
module uart_tx_dp
  import uart_tx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                baudTick,
  input  logic                wrStrobe,
  input  logic [WORD_MAX-1:0] wrData,
  input  logic [5:0]          lineCtrl,
  input  txStrobe_t           stb,
  output logic                bitEnd,
  output logic                lastData,
  output logic                parEn,
  output logic                twoStop,
  output logic                bufFull,
  output logic                txOut
);

  localparam int TICK_W = (OSR > 1) ? $clog2(OSR) : 1;
  localparam int BIT_W  = $clog2(WORD_MAX);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(OSR - 1);

  logic [WORD_MAX-1:0] holdReg, shiftReg, dataMask;
  logic [TICK_W-1:0]   tickCnt;
  logic [BIT_W-1:0]    bitCnt;
  logic [1:0]          lenCode;
  logic                stopCfg, parEnR, parBit, parNext, onesOdd;

  // parity is worked out from the buffered character as it is loaded
  assign dataMask = {WORD_MAX{1'b1}} >> (2'd3 - lineCtrl[1:0]);
  assign onesOdd  = ^(holdReg & dataMask);

  always_comb begin
    case (lineCtrl[4:3])
      2'b00:   parNext = ~onesOdd;
      2'b01:   parNext = onesOdd;
      2'b10:   parNext = 1'b1;
      default: parNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdReg  <= '0;
      bufFull  <= 1'b0;
      shiftReg <= '0;
      tickCnt  <= '0;
      bitCnt   <= '0;
      lenCode  <= '0;
      stopCfg  <= 1'b0;
      parEnR   <= 1'b0;
      parBit   <= 1'b0;
    end else begin
      if (stb.clrTick)
        tickCnt <= '0;
      else if (baudTick)
        tickCnt <= (tickCnt == TICK_LAST) ? '0 : tickCnt + 1'b1;

      if (stb.load) begin
        shiftReg <= holdReg;
        lenCode  <= lineCtrl[1:0];
        stopCfg  <= lineCtrl[2];
        parEnR   <= lineCtrl[5];
        parBit   <= parNext;
        bitCnt   <= '0;
        bufFull  <= 1'b0;
      end else begin
        if (stb.shift) begin
          shiftReg <= shiftReg >> 1;
          bitCnt   <= bitCnt + 1'b1;
        end
        if (wrStrobe && !bufFull) begin
          holdReg <= wrData;
          bufFull <= 1'b1;
        end
      end
    end
  end

  assign bitEnd   = baudTick && (tickCnt == TICK_LAST);
  assign lastData = (bitCnt == BIT_W'(WORD_MIN - 1) + BIT_W'(lenCode));
  assign parEn    = parEnR;
  assign twoStop  = stopCfg;

  always_comb begin
    case (stb.lineSel)
      LN_SPACE: txOut = 1'b0;
      LN_DATA:  txOut = shiftReg[0];
      LN_PAR:   txOut = parBit;
      default:  txOut = 1'b1;
    endcase
  end

endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sendBreak,
  input  logic      bitEnd,
  input  logic      lastData,
  input  logic      parEn,
  input  logic      twoStop,
  input  logic      bufFull,
  output txStrobe_t stb,
  output logic      txDone
);

  txState_t state, nextState;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end

  always_comb begin
    nextState   = state;
    stb.load    = 1'b0;
    stb.shift   = 1'b0;
    stb.clrTick = 1'b0;
    case (state)
      ST_START, ST_BRK: stb.lineSel = LN_SPACE;
      ST_DATA:          stb.lineSel = LN_DATA;
      ST_PAR:           stb.lineSel = LN_PAR;
      default:          stb.lineSel = LN_MARK;
    endcase

    if (sendBreak) begin
      // break wins over every state and keeps the bit timer at zero
      nextState   = ST_BRK;
      stb.clrTick = 1'b1;
    end else begin
      case (state)
        ST_IDLE:
          if (bufFull) begin
            stb.load    = 1'b1;
            stb.clrTick = 1'b1;
            nextState   = ST_START;
          end
        ST_START:
          if (bitEnd) nextState = ST_DATA;
        ST_DATA:
          if (bitEnd) begin
            stb.shift = 1'b1;
            if (lastData) nextState = parEn ? ST_PAR : ST_STOP1;
          end
        ST_PAR:
          if (bitEnd) nextState = ST_STOP1;
        ST_STOP1:
          if (bitEnd) nextState = twoStop ? ST_STOP2 : ST_IDLE;
        ST_STOP2, ST_BRKREC:
          if (bitEnd) nextState = ST_IDLE;
        ST_BRK: begin
          nextState   = ST_BRKREC;
          stb.clrTick = 1'b1;
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  assign txDone = (state == ST_IDLE) && !bufFull;

endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_tx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                baudTick,
  input  logic [5:0]          lineCtrl,
  input  logic                sendBreak,
  input  logic                wrStrobe,
  input  logic [WORD_MAX-1:0] wrData,
  output logic                txOut,
  output logic                bufEmpty,
  output logic                txDone
);

  txStrobe_t stb;
  logic bitEnd, lastData, parEn, twoStop, bufFull;

  uart_tx_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .sendBreak(sendBreak),
    .bitEnd   (bitEnd),
    .lastData (lastData),
    .parEn    (parEn),
    .twoStop  (twoStop),
    .bufFull  (bufFull),
    .stb      (stb),
    .txDone   (txDone)
  );

  uart_tx_dp #(.OSR(OSR)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .baudTick(baudTick),
    .wrStrobe(wrStrobe),
    .wrData  (wrData),
    .lineCtrl(lineCtrl),
    .stb     (stb),
    .bitEnd  (bitEnd),
    .lastData(lastData),
    .parEn   (parEn),
    .twoStop (twoStop),
    .bufFull (bufFull),
    .txOut   (txOut)
  );

  assign bufEmpty = !bufFull;

endmodule

// File: rtl/uart_tx_chk.sv
module uart_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic sendBreak,
  input logic wrStrobe,
  input logic txOut,
  input logic bufEmpty,
  input logic txDone
);

  // R9: a break seen on the previous edge holds the line low
  p_break_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sendBreak) && $past(rst_n)) |-> !txOut);

  // R10: releasing break returns the line to mark at once
  p_break_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sendBreak) |=> txOut);

  // R5: a quiet transmitter drives mark
  p_quiet_mark_r5: assert property (@(posedge clk) disable iff (!rst_n)
    txDone |-> txOut);

  // R8: quiet implies an empty holding buffer
  p_quiet_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    txDone |-> bufEmpty);

  // R6: an empty buffer stays empty without a write
  p_empty_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bufEmpty && !wrStrobe) |=> bufEmpty);

  // R6: a write into an empty buffer is taken
  p_write_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bufEmpty && wrStrobe) |=> !bufEmpty);

endmodule

bind uart_tx uart_tx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sendBreak(sendBreak),
  .wrStrobe (wrStrobe),
  .txOut    (txOut),
  .bufEmpty (bufEmpty),
  .txDone   (txDone)
);

// File: tb/uart_tx_test.sv
module uart_tx_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baudTick = 1'b0;
  logic [5:0] lineCtrl = 6'h03;
  logic       sendBreak = 1'b0;
  logic       wrStrobe = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       txOut, bufEmpty, txDone;

  uart_tx uut (
    .clk(clk), .rst_n(rst_n), .baudTick(baudTick), .lineCtrl(lineCtrl),
    .sendBreak(sendBreak), .wrStrobe(wrStrobe), .wrData(wrData),
    .txOut(txOut), .bufEmpty(bufEmpty), .txDone(txDone)
  );

  always #5 clk = ~clk;

  int nChecks = 0;
  int nFails = 0;
  logic [13:0] expQ[$];
  bit   rxEn = 1'b1;
  bit   rxBusy = 1'b0;
  int   rxCnt = 0;
  int   rxLen = 0;
  logic [15:0] rxBits = '1;
  logic [5:0]  rxLc = '0;
  int   tickCount = 0;
  int   doneViol = 0;
  int   divCnt = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  function automatic int wordLen(input logic [5:0] lc);
    return 5 + int'(lc[1:0]);
  endfunction

  function automatic int frameLen(input logic [5:0] lc);
    return 2 + wordLen(lc) + int'(lc[5]) + int'(lc[2]);
  endfunction

  function automatic logic expParity(input logic [7:0] d, input logic [5:0] lc);
    logic x;
    x = 1'b0;
    for (int i = 0; i < wordLen(lc); i++) x ^= d[i];
    case (lc[4:3])
      2'b00:   return ~x;
      2'b01:   return x;
      2'b10:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [15:0] frameBits(input logic [7:0] d, input logic [5:0] lc);
    logic [15:0] b;
    int n;
    b = '1;
    n = wordLen(lc);
    b[0] = 1'b0;
    for (int i = 0; i < n; i++) b[i+1] = d[i];
    if (lc[5]) b[n+1] = expParity(d, lc);
    return b;
  endfunction

  function automatic string reqFor(input int idx, input logic [5:0] lc);
    int n;
    n = wordLen(lc);
    if (idx == 0) return "R4 start bit";
    if (idx <= n) return "R1/R4 data bit";
    if (lc[5] && idx == n + 1) return "R3 parity bit";
    return "R2 stop bit";
  endfunction

  // model receiver, stepped once per baud tick
  task automatic rxStep();
    logic [13:0] it;
    int idx;
    if (!rxBusy) begin
      if (!txOut) begin
        rxBusy = 1'b1;
        rxCnt = 0;
        if (expQ.size() == 0) begin
          check(1'b0, "R7 unexpected frame", 1, 0);
          rxLc = 6'h03; rxBits = '1; rxLen = 10;
        end else begin
          it = expQ.pop_front();
          rxLc = it[13:8];
          rxBits = frameBits(it[7:0], it[13:8]);
          rxLen = frameLen(it[13:8]);
        end
      end
    end else begin
      rxCnt++;
      if (txDone) doneViol++;
      if (rxCnt % 16 == 8) begin
        idx = rxCnt / 16;
        check(txOut == rxBits[idx], reqFor(idx, rxLc), int'(txOut), int'(rxBits[idx]));
        if (idx == rxLen - 1) rxBusy = 1'b0;
      end
    end
  endtask

  // tick source and receiver sampling, both on the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (baudTick) begin
        tickCount++;
        if (rxEn) rxStep();
      end
      divCnt = (divCnt + 1) % 4;
      baudTick = rst_n && (divCnt == 0);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL R8 watchdog: actual hung expected quiet");
    finishRun();
  end

  task automatic sendChar(input logic [7:0] d);
    while (!bufEmpty) @(negedge clk);
    wrStrobe = 1'b1;
    wrData = d;
    expQ.push_back({lineCtrl, d});
    @(negedge clk);
    wrStrobe = 1'b0;
  endtask

  task automatic waitDone();
    do @(negedge clk); while (!(txDone && !rxBusy));
    repeat (8) @(negedge clk);
    check(txOut == 1'b1, "R5 idle line high", int'(txOut), 1);
  endtask

  initial begin
    int lowViol;
    int t0;
    logic [2:0] pm;
    void'($urandom(32'd4517));
    repeat (4) @(negedge clk);
    check(txOut == 1'b1, "R5 reset line", int'(txOut), 1);
    check(bufEmpty == 1'b1, "R6 reset empty", int'(bufEmpty), 1);
    check(txDone == 1'b1, "R8 reset quiet", int'(txDone), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // write, hand-off collision, write while full
    lineCtrl = 6'h03;
    sendChar(8'hA5);
    check(bufEmpty == 1'b0, "R6 write taken", int'(bufEmpty), 0);
    check(txDone == 1'b0, "R8 busy after write", int'(txDone), 0);
    wrStrobe = 1'b1; wrData = 8'h3C;   // same cycle as hand-off: buffer still full
    @(negedge clk);
    wrStrobe = 1'b0;
    check(bufEmpty == 1'b1, "R6 hand-off frees buffer", int'(bufEmpty), 1);
    check(txDone == 1'b0, "R8 shifter busy", int'(txDone), 0);
    sendChar(8'h4E);
    check(bufEmpty == 1'b0, "R7 buffer full", int'(bufEmpty), 0);
    wrStrobe = 1'b1; wrData = 8'h77;   // ignored: buffer full
    @(negedge clk);
    wrStrobe = 1'b0;
    waitDone();

    // every word length and parity mode, stop count alternating
    for (int l = 0; l < 4; l++) begin
      for (int p = 0; p < 5; p++) begin
        pm = (p == 0) ? 3'b000 : 3'(3 + p);
        lineCtrl = {pm, 1'(p ^ l) , 2'(l)};
        sendChar(8'($urandom));
        sendChar(8'($urandom));
        waitDone();
      end
    end

    // random settings and characters
    for (int r = 0; r < 12; r++) begin
      lineCtrl = 6'($urandom);
      for (int k = 0; k < 3; k++) sendChar(8'($urandom));
      waitDone();
    end

    // break in the middle of a frame, with a write during the break
    lineCtrl = 6'h03;
    sendChar(8'h55);
    repeat (120) @(negedge clk);
    sendBreak = 1'b1;
    rxEn = 1'b0;
    rxBusy = 1'b0;
    @(negedge clk);
    check(txOut == 1'b0, "R9 break takes effect", int'(txOut), 0);
    sendChar(8'h81);
    check(bufEmpty == 1'b0, "R9 buffer keeps char", int'(bufEmpty), 0);
    lowViol = 0;
    repeat (300) begin
      @(negedge clk);
      if (txOut) lowViol++;
    end
    check(lowViol == 0, "R9 line held low", lowViol, 0);
    check(bufEmpty == 1'b0, "R9 char not sent in break", int'(bufEmpty), 0);
    sendBreak = 1'b0;
    t0 = tickCount;
    repeat (3) @(negedge clk);
    rxEn = 1'b1;
    do @(negedge clk); while (txOut && (tickCount - t0 < 200));
    check((tickCount - t0) >= 16, "R10 recovery gap ticks", tickCount - t0, 16);
    waitDone();

    check(expQ.size() == 0, "R7 no character lost", expQ.size(), 0);
    check(doneViol == 0, "R8 quiet flag during frame", doneViol, 0);
    finishRun();
  end

endmodule